// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in in a single combinational pass. A front stage forms, for every bit, a propagate term (the XOR of the two operand bits) and a generate term (their AND). The bits are split into groups of a fixed radix. Inside each group, a lookahead unit works out every internal carry from fully expanded sum-of-products equations, so no carry ripples from bit to bit. Each group also reports a group propagate and a group generate.

A second lookahead unit of the same kind takes these group terms as its inputs. It computes the carry into every group at once, so no carry ripples from group to group. A small output stage combines the overall group terms with the carry-in to form the carry-out. Each sum bit is the propagate term XORed with the carry into that bit.

The default is a 16-bit adder: four radix-4 groups under one radix-4 upper unit. When the width equals the radix, the upper unit is left out.

Top module: `cla_adder`

## Requirements
- R1: For every operand pair and carry-in, {cout, sum} equals a + b + cin, computed as a (WIDTH+1)-bit unsigned value.
- R2: The carry-in enters at bit 0: with a = 0, b = 0 and cin = 1, sum is 1 and cout is 0.
- R3: The carry into bit i+1 equals g_i OR (p_i AND carry into bit i), with p_i = a_i XOR b_i and g_i = a_i AND b_i. A carry-in of 1 with a all ones and b zero therefore passes through every group: sum is 0 and cout is 1.
- R4: grp_p is 1 exactly when a_i XOR b_i is 1 for every bit i.
- R5: grp_g is 1 exactly when the addition produces a carry out of the top bit with cin = 0. That is the OR over i of g_i ANDed with p_j for every j > i.
- R6: cout equals grp_g OR (grp_p AND cin).
- R7: grp_p and grp_g are never 1 at the same time.
- R8: A carry generated in the lowest group reaches the top as cout when every higher bit propagates. In that case grp_g is 1 and grp_p is 0, whatever the value of cin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |
| grp_p | output | 1 | Whole-word propagate |
| grp_g | output | 1 | Whole-word generate |

## Verification
A carry generated inside one group and a carry passing across the boundaries of the other groups can occur in the same evaluation. That case exercises the upper lookahead unit and the lower units together. It is provoked with a low group whose top bits generate while every higher bit has exactly one operand set, and it is applied with both values of cin. It is judged by the full sum, by cout against a + b + cin, and by grp_g = 1 with grp_p = 0. Patterns from a shift register, together with the all-ones and all-zero cases, cover the other combinations of propagate and generate.

// File: rtl/cla_pkg.sv
package cla_pkg;
   localparam int unsigned CLA_DEF_WIDTH = 16;
   localparam int unsigned CLA_DEF_RADIX = 4;

   function automatic int unsigned cla_groups(input int unsigned width, input int unsigned radix);
      return width / radix;
   endfunction
endpackage

// File: rtl/cla_bit_stage.sv
module cla_bit_stage #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic [W-1:0] carry_in_bits,
   output logic [W-1:0] prop,
   output logic [W-1:0] gen,
   output logic [W-1:0] sum_bits
);
   always_comb begin
      prop     = op_a ^ op_b;
      gen      = op_a & op_b;
      sum_bits = prop ^ carry_in_bits;
   end

   // a bit cannot both generate and propagate (R7 rests on this)
   always_comb begin
      p_bit_exclusive_r7: assert ((prop & gen) == '0)
         else $error("bit propagate and generate overlap");
   end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
   parameter int unsigned RADIX = 4
) (
   input  logic [RADIX-1:0] p_in,
   input  logic [RADIX-1:0] g_in,
   input  logic             c_in,
   output logic [RADIX-1:0] c_out,
   output logic             blk_p,
   output logic             blk_g
);
   generate
      if (RADIX < 1) begin : g_bad_radix
         $error("cla_lookahead: RADIX must be at least 1");
      end
   endgenerate

   // flat sum-of-products carries, no ripple inside the unit
   always_comb begin
      logic acc;
      logic term;
      for (int i = 0; i < RADIX; i++) begin
         acc = c_in;
         for (int j = 0; j < i; j++) acc = acc & p_in[j];
         for (int j = 0; j < i; j++) begin
            term = g_in[j];
            for (int k = j + 1; k < i; k++) term = term & p_in[k];
            acc = acc | term;
         end
         c_out[i] = acc;
      end
   end

   always_comb begin
      logic gacc;
      logic gterm;
      gacc = 1'b0;
      for (int i = 0; i < RADIX; i++) begin
         gterm = g_in[i];
         for (int j = i + 1; j < RADIX; j++) gterm = gterm & p_in[j];
         gacc = gacc | gterm;
      end
      blk_g = gacc;
      blk_p = &p_in;
   end

   // flat carries must agree with the one-step recurrence
   always_comb begin
      p_first_carry_r2: assert (c_out[0] == c_in)
         else $error("carry 0 differs from carry-in");
      for (int i = 1; i < RADIX; i++) begin
         p_ripple_rule_r3: assert (c_out[i] == (g_in[i-1] | (p_in[i-1] & c_out[i-1])))
            else $error("carry %0d breaks recurrence", i);
      end
      p_group_exclusive_r7: assert (!(blk_p && blk_g))
         else $error("group propagate and generate both set");
   end
endmodule

// File: rtl/cla_carry_out.sv
module cla_carry_out (
   input  logic top_p,
   input  logic top_g,
   input  logic c_in,
   output logic c_out
);
   always_comb c_out = top_g | (top_p & c_in);
endmodule

// File: rtl/cla_adder.sv
module cla_adder
   import cla_pkg::*;
#(
   parameter int unsigned WIDTH = CLA_DEF_WIDTH,
   parameter int unsigned RADIX = CLA_DEF_RADIX
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             grp_p,
   output logic             grp_g
);
   localparam int unsigned GROUPS = cla_groups(WIDTH, RADIX);

   generate
      if (RADIX < 2 || WIDTH % RADIX != 0) begin : g_bad_split
         $error("cla_adder: WIDTH must be a multiple of RADIX >= 2");
      end
      if (GROUPS > RADIX) begin : g_bad_depth
         $error("cla_adder: WIDTH exceeds two lookahead levels");
      end
   endgenerate

   logic [WIDTH-1:0]  p_bits, g_bits, c_bits;
   logic [GROUPS-1:0] gp, gg, gc;
   logic              top_p, top_g;

   cla_bit_stage #(.W(WIDTH)) u_bits (
      .op_a(a), .op_b(b), .carry_in_bits(c_bits),
      .prop(p_bits), .gen(g_bits), .sum_bits(sum)
   );

   for (genvar k = 0; k < GROUPS; k++) begin : g_grp
      cla_lookahead #(.RADIX(RADIX)) u_la (
         .p_in (p_bits[k*RADIX +: RADIX]),
         .g_in (g_bits[k*RADIX +: RADIX]),
         .c_in (gc[k]),
         .c_out(c_bits[k*RADIX +: RADIX]),
         .blk_p(gp[k]),
         .blk_g(gg[k])
      );
   end

   if (GROUPS > 1) begin : g_upper
      cla_lookahead #(.RADIX(GROUPS)) u_top (
         .p_in(gp), .g_in(gg), .c_in(cin),
         .c_out(gc), .blk_p(top_p), .blk_g(top_g)
      );
   end else begin : g_single
      always_comb begin
         gc    = cin;
         top_p = gp[0];
         top_g = gg[0];
      end
   end

   cla_carry_out u_cout (
      .top_p(top_p), .top_g(top_g), .c_in(cin), .c_out(cout)
   );

   always_comb begin
      grp_p = top_p;
      grp_g = top_g;
   end

   always_comb begin
      p_sum_total_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
         else $error("sum mismatch");
      p_cout_rule_r6: assert (cout == (grp_g | (grp_p & cin)))
         else $error("cout disagrees with group terms");
      p_top_gen_r5: assert (grp_g == (({1'b0, a} + {1'b0, b}) >> WIDTH))
         else $error("grp_g disagrees with carry at cin=0");
   end
endmodule

// File: tb/tb_cla_adder.sv
module tb_cla_adder;
   localparam int W = 16;
   localparam int WATCHDOG = 100000;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [W-1:0] a, b, sum;
   logic cin, cout, grp_p, grp_g;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   cla_adder #(.WIDTH(W), .RADIX(4)) dut (
      .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .grp_p(grp_p), .grp_g(grp_g)
   );

   task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", req, a, b, cin, act, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
      @(negedge clk);
      a = va; b = vb; cin = vc;
      #1;
   endtask

   // checks R1, R4, R5, R6, R7 on the current inputs
   task automatic check_all();
      logic [W:0] total;
      logic [W:0] nocarry;
      logic ep, eg;
      total   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      nocarry = {1'b0, a} + {1'b0, b};
      ep = &(a ^ b);
      eg = nocarry[W];
      chk("R1", {cout, sum}, total);
      chk("R4", {{W{1'b0}}, grp_p}, {{W{1'b0}}, ep});
      chk("R5", {{W{1'b0}}, grp_g}, {{W{1'b0}}, eg});
      chk("R6", {{W{1'b0}}, cout}, {{W{1'b0}}, eg | (ep & cin)});
      chk("R7", {{W{1'b0}}, grp_p & grp_g}, '0);
   endtask

   task automatic t_zero();
      apply('0, '0, 1'b0);
      chk("R1", {cout, sum}, '0);
      chk("R5", {{W{1'b0}}, grp_g}, '0);
   endtask

   task automatic t_cin_only();
      apply('0, '0, 1'b1);
      chk("R2", {cout, sum}, {{W{1'b0}}, 1'b1});
   endtask

   task automatic t_full_propagate();
      apply('1, '0, 1'b1);
      chk("R3", {cout, sum}, {1'b1, {W{1'b0}}});
      chk("R4", {{W{1'b0}}, grp_p}, {{W{1'b0}}, 1'b1});
      apply('0, '1, 1'b0);
      chk("R3", {cout, sum}, {1'b0, {W{1'b1}}});
      check_all();
   endtask

   task automatic t_group_generate();
      for (int c = 0; c < 2; c++) begin
         apply(16'hFFF8, 16'h0008, c[0]);
         chk("R8", {cout, sum}, {1'b1, 15'h0000, c[0]});
         chk("R8", {{(W-1){1'b0}}, grp_g, grp_p}, {{(W-1){1'b0}}, 2'b10});
         check_all();
      end
      apply(16'h00F0, 16'h0010, 1'b0);
      chk("R3", {cout, sum}, {1'b0, 16'h0100});
   endtask

   task automatic t_extremes();
      apply('1, '1, 1'b1);
      chk("R1", {cout, sum}, {1'b1, {W{1'b1}}});
      check_all();
      apply(16'h8000, 16'h8000, 1'b0);
      chk("R5", {{W{1'b0}}, grp_g}, {{W{1'b0}}, 1'b1});
      check_all();
   endtask

   task automatic t_patterns();
      logic [31:0] lfsr;
      lfsr = 32'hACE1_2468;
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         apply(lfsr[15:0], (i % 5 == 0) ? ~lfsr[15:0] : lfsr[31:16], lfsr[7]);
         check_all();
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      a = '0; b = '0; cin = 1'b0;
      repeat (2) @(negedge clk);
      t_zero();
      t_cin_only();
      t_full_propagate();
      t_group_generate();
      t_extremes();
      t_patterns();
      finish_run();
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end
endmodule